// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Generator

This block drives the six gate signals of a three-phase inverter bridge, one high-side and one low-side signal for each of phases A, B and C. A 16-bit timebase counts up from zero to the half-period value and back down. Each phase compares the count against its duty value, so the on-time of every pulse is centred on the middle of the switching period.

Between the two switches of a leg the block inserts a guard interval. Pulses that become too narrow after that interval is removed are dropped. Period and duty values are captured into shadow registers at each period start and, in double-update mode, also at the half-period point. After those stages, each phase can have its high and low signals swapped for brushless commutation. Each pin can be masked, and either side group can be gated by a chopping carrier for transformer-coupled drivers.

A trip input switches every gate off at once and keeps it off until a clear pulse arrives. A one-cycle sync pulse marks the start of each period.

Top module: `tri_phase_pwm`

## Requirements
- R1: The effective half period P is `cfg_period`, raised to 2 when smaller. One PWM period lasts 2P clocks, and `sync_pulse` is high for exactly one clock at its start. Sample index i counts clocks from the sync cycle (i = 0). The first `sync_pulse` appears on the second clock after reset is released.
- R2: The shift is S = 2 × `cfg_dead`, and duty D is taken from the shadow. A phase's high signal is on at index i when its timebase count c(i) ≥ P − D + S. Here c(i) = i in the first half and 2P − 1 − i in the second half. This gives D − S clocks of high per half, and the first high sample is at index P − D + S.
- R3: A phase's low signal is on when c(i) < P − D − S, giving P − D − S clocks per half. The high and low signals of a pin pair are never on together.
- R4: A duty value above P acts as P, so the high side is on for the whole period and the low side stays off.
- R5: The per-half pulse length is measured after the shift. A length of zero or less, or a length below `cfg_min_pulse`, deletes that pulse. A length equal to `cfg_min_pulse` is kept.
- R6: With `cfg_double` low, period, duty, dead-time and minimum-pulse inputs take effect only at a period start. A duty change made during a period does not alter that period.
- R7: With `cfg_double` high, period and duty are also captured at the half-period point. A duty change made during the first half takes effect in the second half.
- R8: `cfg_xover[p]` = 1 swaps the high and low signals of phase p (bit 0 = A, 1 = B, 2 = C).
- R9: `cfg_out_en` bits 0..2 enable the high pins of A, B and C, and bits 3..5 enable the low pins. A cleared bit holds that pin low.
- R10: The chopping carrier is on at index i when floor(i / (`cfg_chop_div` + 1)) is even. `cfg_chop_hi` gates all high pins with it, and `cfg_chop_lo` gates all low pins.
- R11: `trip_in` high forces all six gates low at once, without waiting for a clock. It also sets `tripped` at the next clock. `tripped` holds the gates low until a `trip_clear` pulse arrives while `trip_in` is low. A clear given while `trip_in` is high is ignored.
- R12: While reset is asserted, all gates and `sync_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_period | input | CW | Half-period length in clocks |
| cfg_duty_a | input | CW | Phase A duty (half on-time) |
| cfg_duty_b | input | CW | Phase B duty |
| cfg_duty_c | input | CW | Phase C duty |
| cfg_dead | input | DTW | Guard value; each edge moves by twice this |
| cfg_min_pulse | input | CW | Shortest per-half pulse that is kept |
| cfg_double | input | 1 | 1 = also capture at half period |
| cfg_xover | input | 3 | Per-phase high/low swap |
| cfg_out_en | input | 6 | Per-pin enable (high pins in bits 0..2, low pins in bits 3..5) |
| cfg_chop_hi | input | 1 | Gate high pins with the chopping carrier |
| cfg_chop_lo | input | 1 | Gate low pins with the chopping carrier |
| cfg_chop_div | input | CHW | Carrier half-cycle length minus one |
| trip_in | input | 1 | Asynchronous shutdown request |
| trip_clear | input | 1 | Clears the latched shutdown |
| gate_hi | output | 3 | High-side gates, active high, bit 0 = A |
| gate_lo | output | 3 | Low-side gates, active high, bit 0 = A |
| sync_pulse | output | 1 | One-clock period-start marker |
| tripped | output | 1 | Latched shutdown state |

## Verification
The bench builds the block with its defaults (CW = 16, DTW = 10, CHW = 8). It programs half periods of 8 and 20 clocks, so every sample of a whole period can be counted and its first edge located. Dead values of 1 and 2 and minimum pulses of 5 place the deletion boundary exactly at, and one clock below, the kept length. Carrier dividers of 0 and 1 produce chop patterns whose on-count over a pulse window is known exactly. A mid-period duty change is made in both update modes to show whether the second half follows it.

// File: rtl/pwm3_pkg.sv
// Shared constants and types for the three-phase PWM generator.
// Assumes: phase order A, B, C maps to index 0, 1, 2 everywhere.
package pwm3_pkg;
    localparam int unsigned PHASES   = 3;
    localparam int unsigned MIN_HALF = 2;

    // High/low gate request of one phase before pin mapping.
    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;
endpackage

// File: rtl/pwm_timebase.sv
// Up/down timebase for center-aligned PWM.
// Counts 0..P-1 up and then P-1..0 down, so a full period is 2P clocks.
// It raises the capture strobes for the shadow registers, holds the shadowed
// period, dead and minimum-pulse values, and runs the chopping carrier, which
// restarts at every period start.
// Assumes: synchronous active-low reset. Reset leaves the counter in the last
// cycle of a period, so the first clock after reset captures all settings.
module pwm_timebase #(
    parameter int unsigned CW  = 16,
    parameter int unsigned DTW = 10,
    parameter int unsigned CHW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cfg_period,
    input  logic           cfg_double,
    input  logic [DTW-1:0] cfg_dead,
    input  logic [CW-1:0]  cfg_min_pulse,
    input  logic [CHW-1:0] cfg_chop_div,
    output logic [CW-1:0]  cnt,
    output logic [CW-1:0]  prd_sh,
    output logic [DTW-1:0] dead_sh,
    output logic [CW-1:0]  min_sh,
    output logic           load_full,
    output logic           load_half,
    output logic           period_start,
    output logic           carrier
);
    localparam logic [CW-1:0]  ONE  = CW'(1);
    localparam logic [CW-1:0]  MINP = CW'(pwm3_pkg::MIN_HALF);
    localparam logic [CHW-1:0] CONE = CHW'(1);

    logic           down_q;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  prd_q;
    logic [CW-1:0]  p_eff;
    logic           at_bot;
    logic           at_top;
    logic [CHW-1:0] cc_q;
    logic           cl_q;

    // Clamp the programmed half period to the smallest legal value.
    always_comb p_eff = (cfg_period < MINP) ? MINP : cfg_period;

    // Detect the last cycle of the period and the last cycle of the up half.
    always_comb begin
        at_bot = down_q && (cnt_q == '0);
        at_top = !down_q && (cnt_q == (prd_q - ONE));
    end

    assign load_full    = at_bot;
    assign load_half    = at_top && cfg_double;
    assign period_start = !down_q && (cnt_q == '0);
    assign cnt          = cnt_q;
    assign prd_sh       = prd_q;
    assign carrier      = cl_q;

    // Step the counter and turn it around at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down_q <= 1'b1;
            cnt_q  <= '0;
        end else if (at_bot) begin
            down_q <= 1'b0;
        end else if (at_top) begin
            down_q <= 1'b1;
            if (cfg_double) cnt_q <= p_eff - ONE;
        end else if (down_q) begin
            cnt_q <= cnt_q - ONE;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // Capture the period at each period start, and at mid-period in double mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                      prd_q <= '0;
        else if (load_full || load_half) prd_q <= p_eff;
    end

    // Capture dead time and minimum pulse once per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dead_sh <= '0;
            min_sh  <= '0;
        end else if (load_full) begin
            dead_sh <= cfg_dead;
            min_sh  <= cfg_min_pulse;
        end
    end

    // Chopping carrier: toggle every cfg_chop_div+1 clocks, restart on at each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q <= '0;
            cl_q <= 1'b1;
        end else if (at_bot) begin
            cc_q <= '0;
            cl_q <= 1'b1;
        end else if (cc_q == cfg_chop_div) begin
            cc_q <= '0;
            cl_q <= ~cl_q;
        end else begin
            cc_q <= cc_q + CONE;
        end
    end

    // R1: the count stays below the shadowed half period.
    a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_q != '0) |-> (cnt_q < prd_q));

    // R6: the shadowed period changes only on a capture strobe.
    a_r6_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_full && !load_half) |=> $stable(prd_q));

    // R1: a period start is never followed directly by another.
    a_r1_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);
endmodule

// File: rtl/pwm_phase.sv
// One phase leg comparator.
// Holds the phase's duty shadow and compares the timebase count against
// thresholds that are moved by twice the dead value. Pulses shorter than
// the minimum length are removed.
// Assumes: cnt and prd come from pwm_timebase. Duty is clamped to prd.
module pwm_phase #(
    parameter int unsigned CW  = 16,
    parameter int unsigned DTW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        cnt,
    input  logic [CW-1:0]        prd,
    input  logic [DTW-1:0]       dead,
    input  logic [CW-1:0]        min_len,
    input  logic                 load_full,
    input  logic                 load_half,
    input  logic [CW-1:0]        cfg_duty,
    output pwm3_pkg::gate_pair_t raw
);
    localparam int unsigned     WW   = CW + 3;
    localparam logic signed [WW-1:0] ZERO = '0;

    logic [CW-1:0]        duty_sh;
    logic [CW-1:0]        duty_c;
    logic signed [WW-1:0] prd_s, duty_s, shift_s, min_s, cnt_s, len_h, len_l;

    // Capture the duty value on either strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                      duty_sh <= '0;
        else if (load_full || load_half) duty_sh <= cfg_duty;
    end

    // Clamp the duty value and widen every operand to signed arithmetic.
    always_comb begin
        duty_c  = (duty_sh > prd) ? prd : duty_sh;
        prd_s   = $signed({{(WW-CW){1'b0}}, prd});
        duty_s  = $signed({{(WW-CW){1'b0}}, duty_c});
        min_s   = $signed({{(WW-CW){1'b0}}, min_len});
        cnt_s   = $signed({{(WW-CW){1'b0}}, cnt});
        shift_s = $signed({{(WW-DTW-1){1'b0}}, dead, 1'b0});
    end

    // Per-half pulse lengths after the guard interval is removed.
    always_comb begin
        len_h = duty_s - shift_s;
        len_l = prd_s - duty_s - shift_s;
    end

    // Compare the count against each window, dropping pulses that are too short.
    always_comb begin
        raw.hi = (len_h > ZERO) && (len_h >= min_s) && (cnt_s >= (prd_s - len_h));
        raw.lo = (len_l > ZERO) && (len_l >= min_s) && (cnt_s < len_l);
    end

    // R3: the two sides of a leg are never requested together.
    a_r3_leg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw.hi && raw.lo));

    // R6: the duty shadow is held between capture strobes.
    a_r6_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_full && !load_half) |=> $stable(duty_sh));
endmodule

// File: rtl/pwm_outstage.sv
// Output stage: crossover swap, per-pin enable, chopping, output register,
// trip latch and trip gating.
// Assumes: trip_in may change at any time. It gates the pins combinationally,
// so shutdown needs no clock, and it is also sampled into the latch.
module pwm_outstage #(
    parameter int unsigned NP = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  pwm3_pkg::gate_pair_t [NP-1:0] raw,
    input  logic [NP-1:0]                 cfg_xover,
    input  logic [2*NP-1:0]               cfg_out_en,
    input  logic                          cfg_chop_hi,
    input  logic                          cfg_chop_lo,
    input  logic                          carrier,
    input  logic                          period_start,
    input  logic                          trip_in,
    input  logic                          trip_clear,
    output logic [NP-1:0]                 gate_hi,
    output logic [NP-1:0]                 gate_lo,
    output logic                          sync_pulse,
    output logic                          tripped
);
    logic [NP-1:0] nxt_hi, nxt_lo, q_hi, q_lo;
    logic          sync_q, trip_q, kill;

    // Map phase requests to pins, then apply enables and chopping.
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            nxt_hi[p] = (cfg_xover[p] ? raw[p].lo : raw[p].hi) && cfg_out_en[p]
                        && (carrier || !cfg_chop_hi);
            nxt_lo[p] = (cfg_xover[p] ? raw[p].hi : raw[p].lo) && cfg_out_en[NP+p]
                        && (carrier || !cfg_chop_lo);
        end
    end

    // Register the pin levels and the sync marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_hi   <= '0;
            q_lo   <= '0;
            sync_q <= 1'b0;
        end else begin
            q_hi   <= nxt_hi;
            q_lo   <= nxt_lo;
            sync_q <= period_start;
        end
    end

    // Latch a trip. A clear is honoured only while trip_in is low.
    always_ff @(posedge clk) begin
        if (!rst_n)          trip_q <= 1'b0;
        else if (trip_in)    trip_q <= 1'b1;
        else if (trip_clear) trip_q <= 1'b0;
    end

    always_comb kill = trip_in || trip_q;

    assign gate_hi    = q_hi & {NP{!kill}};
    assign gate_lo    = q_lo & {NP{!kill}};
    assign sync_pulse = sync_q;
    assign tripped    = trip_q;

    // R3: the two pins of a leg are never on together, with or without crossover.
    a_r3_pins_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_hi & gate_lo) == '0));

    // R11: a sampled trip request always leaves the latch set.
    a_r11_trip_latches: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trip_in)) |-> tripped);

    // R11: the latch falls only after a clear given while trip_in was low.
    a_r11_clear_rule: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tripped) |-> ($past(trip_clear) && !$past(trip_in)));

    // R11: while latched, no gate is driven.
    a_r11_latched_off: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |-> ((gate_hi | gate_lo) == '0));

    // R1: the sync marker lasts a single clock.
    a_r1_sync_width: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);
endmodule

// File: rtl/tri_phase_pwm.sv
// Top of the center-aligned three-phase PWM generator.
// Connects the timebase, one comparator per phase (generated), and the
// output stage.
// Assumes: configuration inputs are held stable by the surrounding register
// block. Period and duty take effect at capture strobes.
module tri_phase_pwm #(
    parameter int unsigned CW  = 16,
    parameter int unsigned DTW = 10,
    parameter int unsigned CHW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cfg_period,
    input  logic [CW-1:0]  cfg_duty_a,
    input  logic [CW-1:0]  cfg_duty_b,
    input  logic [CW-1:0]  cfg_duty_c,
    input  logic [DTW-1:0] cfg_dead,
    input  logic [CW-1:0]  cfg_min_pulse,
    input  logic           cfg_double,
    input  logic [2:0]     cfg_xover,
    input  logic [5:0]     cfg_out_en,
    input  logic           cfg_chop_hi,
    input  logic           cfg_chop_lo,
    input  logic [CHW-1:0] cfg_chop_div,
    input  logic           trip_in,
    input  logic           trip_clear,
    output logic [2:0]     gate_hi,
    output logic [2:0]     gate_lo,
    output logic           sync_pulse,
    output logic           tripped
);
    localparam int unsigned NP = pwm3_pkg::PHASES;

    logic [CW-1:0]  cnt, prd_sh, min_sh;
    logic [DTW-1:0] dead_sh;
    logic           load_full, load_half, period_start, carrier;
    logic [CW-1:0]  duty_in [NP];
    pwm3_pkg::gate_pair_t [NP-1:0] raw;

    // Gather the per-phase duty inputs into an array for the generate loop.
    always_comb begin
        duty_in[0] = cfg_duty_a;
        duty_in[1] = cfg_duty_b;
        duty_in[2] = cfg_duty_c;
    end

    pwm_timebase #(.CW(CW), .DTW(DTW), .CHW(CHW)) u_tb (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_period   (cfg_period),
        .cfg_double   (cfg_double),
        .cfg_dead     (cfg_dead),
        .cfg_min_pulse(cfg_min_pulse),
        .cfg_chop_div (cfg_chop_div),
        .cnt          (cnt),
        .prd_sh       (prd_sh),
        .dead_sh      (dead_sh),
        .min_sh       (min_sh),
        .load_full    (load_full),
        .load_half    (load_half),
        .period_start (period_start),
        .carrier      (carrier)
    );

    for (genvar p = 0; p < NP; p++) begin : g_phase
        pwm_phase #(.CW(CW), .DTW(DTW)) u_ph (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt),
            .prd      (prd_sh),
            .dead     (dead_sh),
            .min_len  (min_sh),
            .load_full(load_full),
            .load_half(load_half),
            .cfg_duty (duty_in[p]),
            .raw      (raw[p])
        );
    end

    pwm_outstage #(.NP(NP)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw         (raw),
        .cfg_xover   (cfg_xover),
        .cfg_out_en  (cfg_out_en),
        .cfg_chop_hi (cfg_chop_hi),
        .cfg_chop_lo (cfg_chop_lo),
        .carrier     (carrier),
        .period_start(period_start),
        .trip_in     (trip_in),
        .trip_clear  (trip_clear),
        .gate_hi     (gate_hi),
        .gate_lo     (gate_lo),
        .sync_pulse  (sync_pulse),
        .tripped     (tripped)
    );
endmodule

// File: tb/tb_tri_phase_pwm.sv
// Self-checking bench: a vector table of settings with expected pin counts
// over one period, then directed reset, update-mode and trip tests.
module tb_tri_phase_pwm;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic [15:0] prd, da, db;
        logic [9:0]  dead;
        logic [15:0] minp;
        logic [2:0]  xo;
        logic [5:0]  en;
        logic        ch, cl;
        logic [7:0]  div;
        logic [7:0]  e_hia, e_loa, e_hib, e_first;
    } vec_t;

    // Expected per-period counts: high A, low A, high B, first high-A index (255 = none).
    localparam vec_t VECS [12] = '{
        '{16'd20, 16'd10, 16'd10, 10'd1, 16'd0, 3'b000, 6'h3F, 1'b0, 1'b0, 8'd0, 8'd16, 8'd16, 8'd16, 8'd12},  // R2 R3
        '{16'd20, 16'd4,  16'd10, 10'd2, 16'd0, 3'b000, 6'h3F, 1'b0, 1'b0, 8'd0, 8'd0,  8'd24, 8'd12, 8'd255}, // R5 zero length
        '{16'd20, 16'd6,  16'd10, 10'd1, 16'd5, 3'b000, 6'h3F, 1'b0, 1'b0, 8'd0, 8'd0,  8'd24, 8'd16, 8'd255}, // R5 below min
        '{16'd20, 16'd7,  16'd10, 10'd1, 16'd5, 3'b000, 6'h3F, 1'b0, 1'b0, 8'd0, 8'd10, 8'd22, 8'd16, 8'd15},  // R5 equal min
        '{16'd20, 16'd20, 16'd10, 10'd0, 16'd0, 3'b000, 6'h3F, 1'b0, 1'b0, 8'd0, 8'd40, 8'd0,  8'd20, 8'd0},   // R4 full
        '{16'd20, 16'd25, 16'd10, 10'd0, 16'd0, 3'b000, 6'h3F, 1'b0, 1'b0, 8'd0, 8'd40, 8'd0,  8'd20, 8'd0},   // R4 clamp
        '{16'd20, 16'd0,  16'd10, 10'd0, 16'd0, 3'b000, 6'h3F, 1'b0, 1'b0, 8'd0, 8'd0,  8'd40, 8'd20, 8'd255}, // R3 zero duty
        '{16'd20, 16'd13, 16'd10, 10'd1, 16'd0, 3'b001, 6'h3F, 1'b0, 1'b0, 8'd0, 8'd10, 8'd22, 8'd16, 8'd0},   // R8
        '{16'd20, 16'd10, 16'd10, 10'd1, 16'd0, 3'b000, 6'h3E, 1'b0, 1'b0, 8'd0, 8'd0,  8'd16, 8'd16, 8'd255}, // R9
        '{16'd20, 16'd10, 16'd10, 10'd1, 16'd0, 3'b000, 6'h3F, 1'b1, 1'b0, 8'd1, 8'd8,  8'd16, 8'd8,  8'd12},  // R10 high
        '{16'd20, 16'd10, 16'd10, 10'd1, 16'd0, 3'b000, 6'h3F, 1'b0, 1'b1, 8'd0, 8'd16, 8'd8,  8'd16, 8'd12},  // R10 low
        '{16'd8,  16'd3,  16'd10, 10'd0, 16'd0, 3'b000, 6'h3F, 1'b0, 1'b0, 8'd0, 8'd6,  8'd10, 8'd16, 8'd5}    // R1 R2 short
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_period = 16'd20, cfg_duty_a = 16'd20, cfg_duty_b = 16'd10, cfg_duty_c = 16'd10;
    logic [9:0]  cfg_dead = '0;
    logic [15:0] cfg_min_pulse = '0;
    logic        cfg_double = 1'b0;
    logic [2:0]  cfg_xover = '0;
    logic [5:0]  cfg_out_en = 6'h3F;
    logic        cfg_chop_hi = 1'b0, cfg_chop_lo = 1'b0;
    logic [7:0]  cfg_chop_div = '0;
    logic        trip_in = 1'b0, trip_clear = 1'b0;
    logic [2:0]  gate_hi, gate_lo;
    logic        sync_pulse, tripped;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    tri_phase_pwm dut (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period),
        .cfg_duty_a(cfg_duty_a), .cfg_duty_b(cfg_duty_b), .cfg_duty_c(cfg_duty_c),
        .cfg_dead(cfg_dead), .cfg_min_pulse(cfg_min_pulse), .cfg_double(cfg_double),
        .cfg_xover(cfg_xover), .cfg_out_en(cfg_out_en), .cfg_chop_hi(cfg_chop_hi),
        .cfg_chop_lo(cfg_chop_lo), .cfg_chop_div(cfg_chop_div), .trip_in(trip_in),
        .trip_clear(trip_clear), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .sync_pulse(sync_pulse), .tripped(tripped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (sync_pulse !== 1'b1);
    endtask

    // Skip one period so new settings are captured, then count pins over the next.
    task automatic measure(input int p, input int chg, output int hia, output int loa,
                           output int hib, output int first, output int per_ok);
        int syncs;
        hia = 0; loa = 0; hib = 0; first = 255; syncs = 0;
        wait_sync();
        wait_sync();
        for (int i = 0; i < 2*p; i++) begin
            if (i > 0) @(negedge clk);
            if (gate_hi[0]) begin hia++; if (first == 255) first = i; end
            if (gate_lo[0]) loa++;
            if (gate_hi[1]) hib++;
            if (sync_pulse) syncs++;
            if (i == 0 && chg >= 0) cfg_duty_a = 16'(chg);
        end
        @(negedge clk);
        per_ok = (syncs == 1 && sync_pulse) ? 1 : 0;
    endtask

    task automatic apply(input vec_t v);
        cfg_period = v.prd; cfg_duty_a = v.da; cfg_duty_b = v.db; cfg_duty_c = v.db;
        cfg_dead = v.dead; cfg_min_pulse = v.minp; cfg_xover = v.xo; cfg_out_en = v.en;
        cfg_chop_hi = v.ch; cfg_chop_lo = v.cl; cfg_chop_div = v.div;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int hia, loa, hib, first, ok;
        // R12: reset holds everything low even with a full-on duty programmed.
        repeat (5) @(negedge clk);
        chk("R12 gates in reset", int'({gate_hi, gate_lo}), 0);
        chk("R12 sync in reset", int'(sync_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 no sync one clock after reset", int'(sync_pulse), 0);
        @(negedge clk);
        chk("R1 first sync two clocks after reset", int'(sync_pulse), 1);
        chk("R4 full duty high at index 0", int'(gate_hi[0]), 1);

        // Table walk: R1..R5, R8..R10.
        for (int k = 0; k < 12; k++) begin
            apply(VECS[k]);
            measure(int'(VECS[k].prd), -1, hia, loa, hib, first, ok);
            chk($sformatf("R2 vec%0d high A count", k), hia, int'(VECS[k].e_hia));
            chk($sformatf("R3 vec%0d low A count", k), loa, int'(VECS[k].e_loa));
            chk($sformatf("R5 vec%0d high B count", k), hib, int'(VECS[k].e_hib));
            chk($sformatf("R2 vec%0d first high index", k), first, int'(VECS[k].e_first));
            chk($sformatf("R1 vec%0d period length", k), ok, 1);
        end

        // R6: single update ignores a mid-period duty change.
        apply(VECS[0]);
        cfg_double = 1'b0;
        measure(20, 6, hia, loa, hib, first, ok);
        chk("R6 single update keeps period duty", hia, 16);
        measure(20, -1, hia, loa, hib, first, ok);
        chk("R6 new duty at next period", hia, 8);

        // R7: double update applies the change in the second half.
        apply(VECS[0]);
        cfg_double = 1'b1;
        measure(20, 6, hia, loa, hib, first, ok);
        chk("R7 double update second half", hia, 12);
        chk("R7 period length in double mode", ok, 1);
        cfg_double = 1'b0;

        // R11: trip behaviour.
        apply(VECS[0]);
        measure(20, -1, hia, loa, hib, first, ok);
        wait_sync();
        repeat (14) @(negedge clk);
        chk("R2 high A on mid window", int'(gate_hi[0]), 1);
        #1 trip_in = 1'b1;
        #1 chk("R11 gates off without a clock", int'({gate_hi, gate_lo}), 0);
        @(negedge clk);
        trip_in = 1'b0;
        @(negedge clk);
        chk("R11 tripped latched", int'(tripped), 1);
        chk("R11 gates held off", int'({gate_hi, gate_lo}), 0);
        trip_in = 1'b1; trip_clear = 1'b1;
        @(negedge clk);
        chk("R11 clear ignored while trip high", int'(tripped), 1);
        trip_in = 1'b0; trip_clear = 1'b0;
        @(negedge clk);
        chk("R11 still latched", int'(tripped), 1);
        trip_clear = 1'b1;
        @(negedge clk);
        trip_clear = 1'b0;
        chk("R11 cleared", int'(tripped), 0);
        measure(20, -1, hia, loa, hib, first, ok);
        chk("R11 output resumes after clear", hia, 16);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule